// File: doc/BRIEF.md
# Sync Output Formatter

This block rebuilds the sync outputs of a video capture front end. It receives the selected horizontal sync, a vertical sync from an integrator, and a raw coast request, all sampled on the pixel clock. It drives four outputs:

- a regenerated horizontal sync;
- a shaped horizontal pulse of programmable width, with its start or its end tied to the lock edge (the rising edge) of the incoming horizontal sync;
- a vertical sync, either re-timed to the horizontal sync or passed through raw;
- an active-high coast signal.

A single control byte chooses the modes and can place the three sync pins in high impedance. It does this through per-pin output-enable signals. The internal timing keeps running while the pins are disabled.

When the pulse must end at the lock edge, its start has to come before that edge. The block therefore counts pixel clocks between successive lock edges. It starts the pulse when the count for the current line reaches the previous line length minus the width. While no previous line length is known, the pulse starts at the lock edge instead.

Top module: `sync_out_formatter`

## Requirements
- R1: While reset is asserted, and right after it, every data output is 0, every output enable is 1 and the control readback is 0x00.
- R2: A write strobe loads all eight control bits, and the readback returns exactly the value written from the clock after the write.
- R3: When control bit 0 is 1, all three output enables are 0; when it is 0, all three are 1. The sync outputs keep their normal timing either way.
- R4: The regenerated horizontal sync equals the horizontal sync input delayed by one clock. The lock edge is a clock where the input is 1 after being 0.
- R5: When control bit 2 is 1, the shaped pulse is 1 for exactly W clocks, starting in the clock where the regenerated sync rises.
- R6: When control bit 2 is 0 and the previous line length L is known, the shaped pulse is 1 for the W clocks that end just before the regenerated sync rises. L is the number of clocks between the last two lock edges.
- R7: When control bit 2 is 0 and no line length is known yet, the shaped pulse behaves as in R5 for that line. Before the first lock edge after reset, the pulse stays 0.
- R8: The width W is taken from an 8-bit input, and a value of 0 is used as 1.
- R9: When control bit 4 is 0, the vertical sync output takes the input value sampled at a lock edge and shows it when the regenerated sync rises. At all other times it holds.
- R10: When control bit 4 is 1, the vertical sync output equals the vertical sync input delayed by one clock.
- R11: The coast output equals the coast input delayed by one clock, inverted when control bit 1 is 1.
- R12: Control bits 3, 5, 6 and 7 change no output other than the readback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ctrlWe | input | 1 | Control byte write strobe |
| ctrlWdata | input | 8 | Control byte write value |
| ctrlRdata | output | 8 | Control byte readback |
| hsyncIn | input | 1 | Selected horizontal sync, active high |
| vsyncRaw | input | 1 | Integrated vertical sync |
| coastIn | input | 1 | Raw coast request |
| hsWidth | input | 8 | Shaped pulse width in pixel clocks |
| hsyncOut | output | 1 | Regenerated horizontal sync |
| hsyncOutEn | output | 1 | Output enable for hsyncOut |
| hsOut | output | 1 | Shaped horizontal pulse |
| hsOutEn | output | 1 | Output enable for hsOut |
| vsyncOut | output | 1 | Vertical sync output |
| vsyncOutEn | output | 1 | Output enable for vsyncOut |
| coastActive | output | 1 | Coast, active high |

## Verification
The leading-edge pulse property assumes that the width input and the anchor mode were steady over the two clocks before a pulse starts. Without that, a widened pulse mid-line could begin away from a lock edge. The stimulus therefore changes width and mode only between groups of whole lines. Each line is kept at least three clocks longer than the effective width, and each horizontal sync high time is shorter than the line, so every line has a clean lock edge. The vertical sync and coast inputs toggle freely on any clock, since the properties for them make no assumption about their timing.

// File: rtl/sofmt_pkg.sv
package sofmt_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int CTRL_W = 8;

  // control bit positions decoded by the control path
  localparam int CTL_TRISTATE = 0;
  localparam int CTL_COAST_LOW = 1;
  localparam int CTL_LEAD_LOCK = 2;
  localparam int CTL_VS_RAW = 4;

  // strobes from control to datapath
  typedef struct packed {
    logic lockEdge;
    logic hsOutNext;
    logic vsLoad;
  } fmtStrobe_t;
endpackage

// File: rtl/sofmt_ctrl.sv
module sofmt_ctrl
  import sofmt_pkg::*;
#(
  parameter int CNT_W = 12,
  parameter int WID_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWe,
  input  logic [CTRL_W-1:0] ctrlWdata,
  output logic [CTRL_W-1:0] ctrlReg,
  input  logic              hsyncIn,
  input  logic [WID_W-1:0]  hsWidth,
  output fmtStrobe_t        strobe
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic             hsPrev;
  logic             seenEdge;
  logic             lenValid;
  logic [CNT_W-1:0] pixCnt;
  logic [CNT_W-1:0] lineLen;
  logic             lockEdge;
  logic [WID_W-1:0] widthEff;
  logic [CNT_W-1:0] widthExt;
  logic [CNT_W:0]   endSum;
  logic             predict;
  logic             hsNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg <= '0;
    end else if (ctrlWe) begin
      ctrlReg <= ctrlWdata;
    end
  end

  assign lockEdge = hsyncIn & ~hsPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hsPrev   <= 1'b0;
      seenEdge <= 1'b0;
      lenValid <= 1'b0;
      pixCnt   <= '0;
      lineLen  <= '0;
    end else begin
      hsPrev <= hsyncIn;
      if (lockEdge) begin
        seenEdge <= 1'b1;
        lineLen  <= pixCnt;
        lenValid <= seenEdge & (pixCnt != CNT_MAX);
        pixCnt   <= CNT_W'(1);
      end else if (pixCnt != CNT_MAX) begin
        pixCnt <= pixCnt + CNT_W'(1);
      end
    end
  end

  // width of zero is used as one
  assign widthEff = (hsWidth == '0) ? WID_W'(1) : hsWidth;
  assign widthExt = CNT_W'(widthEff);
  assign endSum   = {1'b0, pixCnt} + {1'b0, widthExt};
  assign predict  = ~ctrlReg[CTL_LEAD_LOCK] & lenValid;

  always_comb begin
    if (!seenEdge && !lockEdge) begin
      hsNext = 1'b0;
    end else if (predict) begin
      // pulse ends at the lock edge; start predicted from last line
      hsNext = ~lockEdge & (endSum >= {1'b0, lineLen});
    end else begin
      hsNext = lockEdge | (pixCnt < widthExt);
    end
  end

  always_comb begin
    strobe.lockEdge  = lockEdge;
    strobe.hsOutNext = hsNext;
    strobe.vsLoad    = lockEdge | ctrlReg[CTL_VS_RAW];
  end
endmodule

// File: rtl/sofmt_dp.sv
module sofmt_dp
  import sofmt_pkg::*;
#(
  parameter int NUM_PINS = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CTRL_W-1:0] ctrlReg,
  input  fmtStrobe_t        strobe,
  input  logic              hsyncIn,
  input  logic              vsyncRaw,
  input  logic              coastIn,
  output logic              hsyncOut,
  output logic              hsOut,
  output logic              vsyncOut,
  output logic              coastActive,
  output logic [NUM_PINS-1:0] pinEn
);
  timeunit 1ns;
  timeprecision 1ps;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hsyncOut    <= 1'b0;
      hsOut       <= 1'b0;
      vsyncOut    <= 1'b0;
      coastActive <= 1'b0;
    end else begin
      hsyncOut    <= hsyncIn;
      hsOut       <= strobe.hsOutNext;
      coastActive <= coastIn ^ ctrlReg[CTL_COAST_LOW];
      if (strobe.vsLoad) begin
        vsyncOut <= vsyncRaw;
      end
    end
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pinEn
    assign pinEn[p] = ~ctrlReg[CTL_TRISTATE];
  end
endmodule

// File: rtl/sync_out_formatter.sv
module sync_out_formatter
  import sofmt_pkg::*;
#(
  parameter int CNT_W = 12,
  parameter int WID_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWe,
  input  logic [7:0]        ctrlWdata,
  output logic [7:0]        ctrlRdata,
  input  logic              hsyncIn,
  input  logic              vsyncRaw,
  input  logic              coastIn,
  input  logic [WID_W-1:0]  hsWidth,
  output logic              hsyncOut,
  output logic              hsyncOutEn,
  output logic              hsOut,
  output logic              hsOutEn,
  output logic              vsyncOut,
  output logic              vsyncOutEn,
  output logic              coastActive
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int NUM_PINS = 3;

  fmtStrobe_t          strobe;
  logic [CTRL_W-1:0]   ctrlReg;
  logic [NUM_PINS-1:0] pinEn;

  sofmt_ctrl #(.CNT_W(CNT_W), .WID_W(WID_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .ctrlWe   (ctrlWe),
    .ctrlWdata(ctrlWdata),
    .ctrlReg  (ctrlReg),
    .hsyncIn  (hsyncIn),
    .hsWidth  (hsWidth),
    .strobe   (strobe)
  );

  sofmt_dp #(.NUM_PINS(NUM_PINS)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctrlReg    (ctrlReg),
    .strobe     (strobe),
    .hsyncIn    (hsyncIn),
    .vsyncRaw   (vsyncRaw),
    .coastIn    (coastIn),
    .hsyncOut   (hsyncOut),
    .hsOut      (hsOut),
    .vsyncOut   (vsyncOut),
    .coastActive(coastActive),
    .pinEn      (pinEn)
  );

  assign ctrlRdata  = ctrlReg;
  assign hsyncOutEn = pinEn[0];
  assign hsOutEn    = pinEn[1];
  assign vsyncOutEn = pinEn[2];
endmodule

// File: rtl/sofmt_chk.sv
module sofmt_chk #(
  parameter int WID_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             ctrlWe,
  input logic [7:0]       ctrlWdata,
  input logic [7:0]       ctrlRdata,
  input logic             hsyncIn,
  input logic             vsyncRaw,
  input logic             coastIn,
  input logic [WID_W-1:0] hsWidth,
  input logic             hsyncOut,
  input logic             hsyncOutEn,
  input logic             hsOut,
  input logic             hsOutEn,
  input logic             vsyncOut,
  input logic             vsyncOutEn,
  input logic             coastActive
);
  timeunit 1ns;
  timeprecision 1ps;

  // R2
  readback_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(ctrlWe) |-> ctrlRdata == $past(ctrlWdata));

  // R3
  tristate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hsOutEn == hsyncOutEn) && (vsyncOutEn == hsOutEn) && (hsOutEn == !ctrlRdata[0]));

  // R4
  hsync_delay_chk: assert property (@(posedge clk) disable iff (!rstN)
    hsyncOut == $past(hsyncIn));

  // R5
  lead_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(hsOut) && $past(ctrlRdata[2]) && $past(ctrlRdata[2], 2)
     && ($past(hsWidth) == $past(hsWidth, 2))) |-> $rose(hsyncOut));

  // R9
  vs_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(ctrlRdata[4]) && !$rose(hsyncOut)) |-> $stable(vsyncOut));

  // R10
  vs_raw_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(ctrlRdata[4]) |-> vsyncOut == $past(vsyncRaw));

  // R11
  coast_pol_chk: assert property (@(posedge clk) disable iff (!rstN)
    coastActive == ($past(coastIn) ^ $past(ctrlRdata[1])));
endmodule

bind sync_out_formatter sofmt_chk #(.WID_W(WID_W)) u_sofmt_chk (
  .clk        (clk),
  .rstN       (rstN),
  .ctrlWe     (ctrlWe),
  .ctrlWdata  (ctrlWdata),
  .ctrlRdata  (ctrlRdata),
  .hsyncIn    (hsyncIn),
  .vsyncRaw   (vsyncRaw),
  .coastIn    (coastIn),
  .hsWidth    (hsWidth),
  .hsyncOut   (hsyncOut),
  .hsyncOutEn (hsyncOutEn),
  .hsOut      (hsOut),
  .hsOutEn    (hsOutEn),
  .vsyncOut   (vsyncOut),
  .vsyncOutEn (vsyncOutEn),
  .coastActive(coastActive)
);

// File: tb/test_sync_out_formatter.sv
module test_sync_out_formatter;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int CNT_MAXV = 4095;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       ctrlWe = 1'b0;
  logic [7:0] ctrlWdata = '0;
  logic [7:0] ctrlRdata;
  logic       hsyncIn = 1'b0;
  logic       vsyncRaw = 1'b0;
  logic       coastIn = 1'b0;
  logic [7:0] hsWidth = 8'd4;
  logic       hsyncOut, hsyncOutEn, hsOut, hsOutEn, vsyncOut, vsyncOutEn, coastActive;

  always #2.5 clk = ~clk;

  sync_out_formatter i_sync_out_formatter (
    .clk(clk), .rstN(rstN), .ctrlWe(ctrlWe), .ctrlWdata(ctrlWdata), .ctrlRdata(ctrlRdata),
    .hsyncIn(hsyncIn), .vsyncRaw(vsyncRaw), .coastIn(coastIn), .hsWidth(hsWidth),
    .hsyncOut(hsyncOut), .hsyncOutEn(hsyncOutEn), .hsOut(hsOut), .hsOutEn(hsOutEn),
    .vsyncOut(vsyncOut), .vsyncOutEn(vsyncOutEn), .coastActive(coastActive)
  );

  int nVec = 0;
  int nMis = 0;
  bit done = 1'b0;

  // reference model state
  logic [7:0] mCtrl = '0;
  bit mPrevH = 1'b0, mSeen = 1'b0, mHaveL = 1'b0;
  int mK = 0, mL = 0;
  bit eHs = 1'b0, eHsync = 1'b0, eVs = 1'b0, eCoast = 1'b0;

  function automatic bit expPulse(bit lead, bit lock, int k, int len, bit haveL, bit seen, int w);
    if (!seen && !lock) return 1'b0;
    if (!lead && haveL) return !lock && (k + w >= len);
    return lock || (k < w);
  endfunction

  task automatic chk1(logic act, bit exp, string tag);
    nVec++;
    if (act !== exp) begin
      nMis++;
      $display("FAIL %s: got %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic chk8(logic [7:0] act, logic [7:0] exp, string tag);
    nVec++;
    if (act !== exp) begin
      nMis++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic tick();
    bit lock;
    int w;
    string hsTag;
    @(posedge clk);
    lock = hsyncIn && !mPrevH;
    w = (hsWidth == 0) ? 1 : int'(hsWidth);
    eHs = expPulse(mCtrl[2], lock, mK, mL, mHaveL, mSeen, w);
    hsTag = mCtrl[2] ? "R5 pulse" : (mHaveL ? "R6 pulse" : "R7 pulse");
    if (hsWidth == 0) hsTag = {hsTag, " R8"};
    if ((mCtrl & 8'hE8) != 0) hsTag = {hsTag, " R12"};
    eHsync = hsyncIn;
    if (mCtrl[4] || lock) eVs = vsyncRaw;
    eCoast = coastIn ^ mCtrl[1];
    if (lock) begin
      if (mSeen) begin
        mL = mK;
        mHaveL = (mK != CNT_MAXV);
      end
      mSeen = 1'b1;
      mK = 1;
    end else if (mK < CNT_MAXV) begin
      mK++;
    end
    mPrevH = hsyncIn;
    if (ctrlWe) mCtrl = ctrlWdata;
    #1;
    chk1(hsOut, eHs, hsTag);
    chk1(hsyncOut, eHsync, "R4 hsync");
    chk1(vsyncOut, eVs, mCtrl[4] ? "R10 vsync raw" : "R9 vsync retimed");
    chk1(coastActive, eCoast, "R11 coast");
    chk1(hsOutEn, !mCtrl[0], "R3 hsOutEn");
    chk1(hsyncOutEn, !mCtrl[0], "R3 hsyncOutEn");
    chk1(vsyncOutEn, !mCtrl[0], "R3 vsyncOutEn");
    chk8(ctrlRdata, mCtrl, "R2 readback");
  endtask

  task automatic writeCtrl(logic [7:0] v);
    ctrlWe = 1'b1;
    ctrlWdata = v;
    tick();
    ctrlWe = 1'b0;
  endtask

  task automatic runLine(int len, int hi);
    for (int c = 0; c < len; c++) begin
      hsyncIn = (c < hi);
      if ($urandom_range(0, 7) == 0) vsyncRaw = ~vsyncRaw;
      coastIn = 1'($urandom_range(0, 1));
      tick();
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nMis);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      nMis++;
      $display("FAIL watchdog all requirements: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7321));
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk1(hsOut, 1'b0, "R1 hsOut");
    chk1(hsyncOut, 1'b0, "R1 hsyncOut");
    chk1(vsyncOut, 1'b0, "R1 vsyncOut");
    chk1(coastActive, 1'b0, "R1 coast");
    chk1(hsOutEn & hsyncOutEn & vsyncOutEn, 1'b1, "R1 enables");
    chk8(ctrlRdata, 8'h00, "R1 readback");
    rstN = 1'b1;

    // R7 then R6: default trailing mode, first line length unknown
    hsWidth = 8'd6;
    for (int i = 0; i < 4; i++) runLine(30, 5);
    // R5 leading mode
    writeCtrl(8'h04);
    hsWidth = 8'd5;
    for (int i = 0; i < 3; i++) runLine(25, 3);
    // R8 width zero in both modes
    hsWidth = 8'd0;
    for (int i = 0; i < 2; i++) runLine(20, 4);
    writeCtrl(8'h00);
    for (int i = 0; i < 3; i++) runLine(20, 4);
    // R10 raw vsync with reserved bits set (R12)
    writeCtrl(8'hF8);
    hsWidth = 8'd9;
    for (int i = 0; i < 3; i++) runLine(40, 6);
    // R3 three-state and R11 inverted coast
    writeCtrl(8'h03);
    for (int i = 0; i < 3; i++) runLine(40, 6);
    // maximum width against a long line
    writeCtrl(8'h00);
    hsWidth = 8'd255;
    for (int i = 0; i < 3; i++) runLine(300, 10);

    // random segments
    for (int s = 0; s < 40; s++) begin
      int w;
      writeCtrl(8'($urandom));
      hsWidth = 8'($urandom_range(0, 20));
      w = (hsWidth == 0) ? 1 : int'(hsWidth);
      for (int i = 0; i < 3; i++) begin
        int len;
        len = $urandom_range(w + 3, 60);
        runLine(len, $urandom_range(1, len - 2));
      end
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule